// File: doc/BRIEF.md
# Single-Wire Bus Wake and Sleep Controller

This block decides when a device on a single-wire open-drain bus is powered. While the device sleeps, it watches the synchronized bus level. A low pulse that lasts long enough counts as a wake break, and a shorter pulse is treated as noise. A wake break turns the regulator on at once, without waiting for the host to release the bus. The block then holds the digital logic in reset for a fixed delay and asks for the configuration to be loaded from non-volatile storage. When the load is done, it pulls the bus low for 1.391 bit-times to tell the host that the device is ready.

Once awake, the block passes the bus level on to the bit receiver, and short low pulses reach it as ordinary data. The device goes back to sleep in two ways. One is a long stretch with no bus transitions, and this works whether the bus rests high or low. The other is a decoded sleep opcode, after which the regulator is cut a few cycles later. Automatic sleep can be switched off at runtime with a register bit. A configuration bit can also switch it off for good. Every duration is a count of reference-clock cycles, and each count is a parameter.

Top module: `swire_power_ctrl`

## Requirements
- R1: While asleep, a low level must be seen on GLITCH_CYC consecutive synchronized samples to wake the device (reg_en_o rises). A pulse one sample shorter leaves reg_en_o at 0. A low level counts only after the bus has been seen high during the current sleep period.
- R2: Power-up starts while the host is still holding the bus low. The release of the bus is not awaited.
- R3: After a wake, reg_en_o is 1 and dig_rst_o is 1 for exactly RST_DLY_CYC cycles. Then dig_rst_o goes to 0 and cfg_load_req_o stays 1 until cfg_done_i is seen. Whenever reg_en_o is 0, dig_rst_o is 1.
- R4: After cfg_done_i, bus_pd_o is 1 for exactly round(BT_CYC*1.391) cycles (22 cycles for BT_CYC=16). bus_pd_o is 1 at no other time.
- R5: While active, IDLE_CYC cycles with no synchronized bus transition put the device to sleep (reg_en_o=0, dig_rst_o=1). This happens with the bus idle high and with the bus idle low. A bus held low into sleep does not wake the device again.
- R6: A runtime auto-sleep enable is set by rst, by every wake and by a soft_rst_i pulse. It is written through aslp_wr_i with aslp_wdata_i. When it is 0, idle time never causes sleep.
- R7: With cfg_aslp_i=0, idle time never causes sleep, whatever the value of the runtime enable.
- R8: A sleep_op_i strobe while active keeps reg_en_o at 1 for exactly SLEEP_DLY_CYC more cycles, after which reg_en_o falls.
- R9: bus_rx_o follows the synchronized bus while active and is 1 otherwise. A short low pulse while active changes neither reg_en_o nor bus_pd_o.
- R10: After reset: reg_en_o=0, dig_rst_o=1, bus_pd_o=0, cfg_load_req_o=0, bus_rx_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_i | input | 1 | Raw bus level |
| sleep_op_i | input | 1 | One-cycle strobe: sleep opcode decoded |
| cfg_done_i | input | 1 | Configuration load finished |
| aslp_wr_i | input | 1 | Write strobe for the runtime auto-sleep enable |
| aslp_wdata_i | input | 1 | Value written to the runtime auto-sleep enable |
| soft_rst_i | input | 1 | Soft reset pulse; sets the runtime auto-sleep enable |
| cfg_aslp_i | input | 1 | Configuration auto-sleep bit (byte 0 bit 2); 0 disables permanently |
| bus_pd_o | output | 1 | Bus pull-down enable |
| reg_en_o | output | 1 | Regulator enable |
| dig_rst_o | output | 1 | Digital core reset |
| cfg_load_req_o | output | 1 | Request to load the configuration |
| bus_rx_o | output | 1 | Synchronized bus to the bit receiver |

## Verification
Low pulses of GLITCH_CYC-1 and GLITCH_CYC samples are driven to find the exact edge of the deglitch filter. A pulse held long past the wake point shows that power-up begins before the host lets go of the bus. Idle periods are run with the bus resting high and with it resting low. They are also run with the runtime enable cleared and with the configuration bit cleared, which separates timeout sleep from each way of blocking it. Pulse widths of the ready break, the reset phase and the delay after a sleep opcode are all measured in exact cycles.

// File: rtl/swp_pkg.sv
package swp_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP   = 3'd0,
    ST_PWRUP   = 3'd1,
    ST_CFG     = 3'd2,
    ST_RDYBRK  = 3'd3,
    ST_ACTIVE  = 3'd4,
    ST_SLPWAIT = 3'd5
  } swp_state_e;

  // Ready-break width: 1.391 bit-times, rounded to whole cycles.
  function automatic int unsigned brk_cycles(input int unsigned bt);
    return (bt * 1391 + 500) / 1000;
  endfunction
endpackage

// File: rtl/swp_bus_filter.sv
module swp_bus_filter #(
  parameter int unsigned GLITCH_CYC = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_i,
  input  logic sleep_i,
  output logic bus_s_o,
  output logic edge_o,
  output logic wake_o
);
  localparam int unsigned CW = $clog2(GLITCH_CYC + 1);

  logic          meta_q, sync_q, prev_q, armed_q;
  logic [CW-1:0] low_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= bus_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  // Low time counts only once the bus has been high during this sleep.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      low_cnt_q <= '0;
    end else begin
      armed_q <= sleep_i && (armed_q || sync_q);
      if (sleep_i && armed_q && !sync_q) begin
        if (low_cnt_q != CW'(GLITCH_CYC)) low_cnt_q <= low_cnt_q + 1'b1;
      end else begin
        low_cnt_q <= '0;
      end
    end
  end

  assign bus_s_o = sync_q;
  assign edge_o  = sync_q ^ prev_q;
  assign wake_o  = sleep_i && armed_q && !sync_q && (low_cnt_q == CW'(GLITCH_CYC - 1));

  AST_WAKE_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (!bus_s_o && sleep_i && $past(!sync_q))); // R1
endmodule

// File: rtl/swp_phase_timer.sv
module swp_phase_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load_i)       cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/swp_idle_timer.sv
module swp_idle_timer #(
  parameter int unsigned LIMIT = 532000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i || kick_i)   cnt_q <= '0;
    else if (cnt_q != W'(LIMIT))   cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == W'(LIMIT));

  AST_IDLE_KICK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    kick_i |=> !expire_o); // R5
endmodule

// File: rtl/swire_power_ctrl.sv
module swire_power_ctrl
  import swp_pkg::*;
#(
  parameter int unsigned GLITCH_CYC    = 11,
  parameter int unsigned RST_DLY_CYC   = 11,
  parameter int unsigned BT_CYC        = 16,
  parameter int unsigned SLEEP_DLY_CYC = 3,
  parameter int unsigned IDLE_CYC      = 532000
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_i,
  input  logic sleep_op_i,
  input  logic cfg_done_i,
  input  logic aslp_wr_i,
  input  logic aslp_wdata_i,
  input  logic soft_rst_i,
  input  logic cfg_aslp_i,
  output logic bus_pd_o,
  output logic reg_en_o,
  output logic dig_rst_o,
  output logic cfg_load_req_o,
  output logic bus_rx_o
);
  localparam int unsigned BRK_CYC = brk_cycles(BT_CYC);
  localparam int unsigned MAX_A   = (RST_DLY_CYC > BRK_CYC) ? RST_DLY_CYC : BRK_CYC;
  localparam int unsigned MAX_LEN = (MAX_A > SLEEP_DLY_CYC) ? MAX_A : SLEEP_DLY_CYC;
  localparam int unsigned TW      = $clog2(MAX_LEN + 1);

  swp_state_e      state_q, state_n;
  logic            bus_s, bus_edge, wake;
  logic            ph_load, ph_done, idle_exp;
  logic [TW-1:0]   ph_len;
  logic            run_en_q, asl_en;

  swp_bus_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filter (
    .clk     (clk),
    .rst     (rst),
    .bus_i   (bus_i),
    .sleep_i (state_q == ST_SLEEP),
    .bus_s_o (bus_s),
    .edge_o  (bus_edge),
    .wake_o  (wake)
  );

  swp_phase_timer #(.W(TW)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .load_i (ph_load),
    .len_i  (ph_len),
    .done_o (ph_done)
  );

  swp_idle_timer #(.LIMIT(IDLE_CYC)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .run_i    (state_q == ST_ACTIVE),
    .kick_i   (bus_edge),
    .expire_o (idle_exp)
  );

  // Runtime auto-sleep enable
  always_ff @(posedge clk) begin
    if (rst || soft_rst_i || wake) run_en_q <= 1'b1;
    else if (aslp_wr_i)            run_en_q <= aslp_wdata_i;
  end

  assign asl_en = run_en_q && cfg_aslp_i;

  always_comb begin
    state_n = state_q;
    ph_load = 1'b0;
    ph_len  = TW'(RST_DLY_CYC);
    unique case (state_q)
      ST_SLEEP: if (wake) begin
        state_n = ST_PWRUP;
        ph_load = 1'b1;
        ph_len  = TW'(RST_DLY_CYC);
      end
      ST_PWRUP: if (ph_done) state_n = ST_CFG;
      ST_CFG: if (cfg_done_i) begin
        state_n = ST_RDYBRK;
        ph_load = 1'b1;
        ph_len  = TW'(BRK_CYC);
      end
      ST_RDYBRK: if (ph_done) state_n = ST_ACTIVE;
      ST_ACTIVE: begin
        if (sleep_op_i) begin
          state_n = ST_SLPWAIT;
          ph_load = 1'b1;
          ph_len  = TW'(SLEEP_DLY_CYC);
        end else if (idle_exp && asl_en) begin
          state_n = ST_SLEEP;
        end
      end
      ST_SLPWAIT: if (ph_done) state_n = ST_SLEEP;
      default: state_n = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_SLEEP;
      reg_en_o       <= 1'b0;
      dig_rst_o      <= 1'b1;
      bus_pd_o       <= 1'b0;
      cfg_load_req_o <= 1'b0;
      bus_rx_o       <= 1'b1;
    end else begin
      state_q        <= state_n;
      reg_en_o       <= (state_n != ST_SLEEP);
      dig_rst_o      <= (state_n == ST_SLEEP) || (state_n == ST_PWRUP);
      bus_pd_o       <= (state_n == ST_RDYBRK);
      cfg_load_req_o <= (state_n == ST_CFG);
      bus_rx_o       <= (state_n == ST_ACTIVE) ? bus_s : 1'b1;
    end
  end

  AST_PD_ONLY_READY: assert property (@(posedge clk) disable iff (rst)
    bus_pd_o |-> (reg_en_o && !dig_rst_o && !cfg_load_req_o)); // R4
  AST_OFF_HOLDS_RESET: assert property (@(posedge clk) disable iff (rst)
    !reg_en_o |-> dig_rst_o); // R3
  AST_RX_IDLE_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    !reg_en_o |-> bus_rx_o); // R9
  AST_NO_AUTO_SLEEP_OFF: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACTIVE && !asl_en && !sleep_op_i) |=> (state_q == ST_ACTIVE)); // R7
  AST_POWERUP_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_en_o) |-> dig_rst_o); // R3
endmodule

// File: tb/swire_power_ctrl_tb.sv
module swire_power_ctrl_tb;
  localparam int unsigned G     = 5;
  localparam int unsigned RSTD  = 6;
  localparam int unsigned BT    = 16;
  localparam int unsigned SLPD  = 3;
  localparam int unsigned IDLE  = 120;
  localparam int          EXP_BRK = 22; // 16 * 1.391 = 22.256 -> 22

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_low = 1'b0;
  logic sleep_op = 1'b0, cfg_done = 1'b0, aslp_wr = 1'b0, aslp_wd = 1'b0;
  logic soft_rst = 1'b0, cfg_aslp = 1'b1;
  logic bus_pd, reg_en, dig_rst, cfg_req, bus_rx;
  logic bus;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_q[$];
  int pd_cnt = 0;

  always #4 clk = ~clk;

  assign bus = !(host_low || bus_pd);

  swire_power_ctrl #(
    .GLITCH_CYC(G), .RST_DLY_CYC(RSTD), .BT_CYC(BT),
    .SLEEP_DLY_CYC(SLPD), .IDLE_CYC(IDLE)
  ) u_dut (
    .clk(clk), .rst(rst), .bus_i(bus), .sleep_op_i(sleep_op),
    .cfg_done_i(cfg_done), .aslp_wr_i(aslp_wr), .aslp_wdata_i(aslp_wd),
    .soft_rst_i(soft_rst), .cfg_aslp_i(cfg_aslp),
    .bus_pd_o(bus_pd), .reg_en_o(reg_en), .dig_rst_o(dig_rst),
    .cfg_load_req_o(cfg_req), .bus_rx_o(bus_rx)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: measures each ready break and compares with the queued width (R4)
  always @(negedge clk) begin
    if (bus_pd) pd_cnt++;
    else if (pd_cnt != 0) begin
      if (exp_q.size() == 0) check("R4 unexpected break", pd_cnt, 0);
      else check("R4 break width", pd_cnt, exp_q.pop_front());
      pd_cnt = 0;
    end
  end

  // Driver: wake with a low pulse of 'hold' samples, then complete the load.
  task automatic wake_seq(input int hold, input bit chk_r2);
    int  rcnt = 0;
    bit  seen = 0;
    host_low = 1'b1;
    for (int i = 1; i <= 200; i++) begin
      tick();
      if (reg_en && host_low) seen = 1;
      if (reg_en && dig_rst) rcnt++;
      if (i == hold) host_low = 1'b0;
      if (cfg_req) break;
    end
    host_low = 1'b0;
    check("R3 reset phase length", rcnt, RSTD);
    if (chk_r2) check("R2 power-up while bus held low", seen, 1);
    check("R3 load requested", cfg_req, 1);
    tick(3);
    check("R3 request held, no break before done", {cfg_req, bus_pd}, 2'b10);
    exp_q.push_back(EXP_BRK);
    cfg_done = 1'b1; tick(); cfg_done = 1'b0;
    tick(EXP_BRK + 6);
    check("R4 request dropped, break over", {cfg_req, bus_pd, reg_en}, 3'b001);
    check("R4 break seen by monitor", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int mn;
    int cnt;
    tick(4);
    rst = 1'b0;
    tick();
    check("R10 reset outputs", {reg_en, dig_rst, bus_pd, cfg_req, bus_rx}, 5'b01001);

    // R1: one sample short
    host_low = 1'b1; tick(G - 1); host_low = 1'b0;
    tick(20);
    check("R1 short pulse ignored", reg_en, 0);

    // R1: exact deglitch length wakes
    wake_seq(G, 0);
    check("R1 pulse of deglitch length wakes", reg_en, 1);

    // R9: short data pulse while active
    check("R9 rx idle high when active", bus_rx, 1);
    mn = 1;
    host_low = 1'b1; tick(2); host_low = 1'b0;
    for (int i = 0; i < 6; i++) begin tick(); if (bus_rx == 0) mn = 0; end
    check("R9 rx follows low pulse", mn, 0);
    check("R9 pulse keeps power state", {reg_en, bus_pd}, 2'b10);

    // R8: sleep opcode
    sleep_op = 1'b1; tick(); sleep_op = 1'b0;
    cnt = 0;
    while (reg_en && cnt < 50) begin cnt++; tick(); end
    check("R8 regulator off delay", cnt, SLPD);
    check("R3 reset while off", dig_rst, 1);

    // R2: wake with long hold, then R5 idle high
    wake_seq(10, 1);
    tick(IDLE - 20);
    check("R5 awake before timeout", reg_en, 1);
    tick(60);
    check("R5 sleep after idle (bus high)", {reg_en, dig_rst}, 2'b01);

    // R5: idle low, no re-wake
    wake_seq(G, 0);
    host_low = 1'b1;
    tick(IDLE + 40);
    check("R5 sleep after idle (bus low)", reg_en, 0);
    tick(30);
    check("R1 bus held low into sleep does not wake", reg_en, 0);
    check("R9 rx high while asleep", bus_rx, 1);
    host_low = 1'b0;
    tick(20);
    check("R1 release does not wake", reg_en, 0);

    // R6: runtime disable, soft reset re-enables
    wake_seq(G, 0);
    aslp_wr = 1'b1; aslp_wd = 1'b0; tick(); aslp_wr = 1'b0;
    tick(IDLE + 40);
    check("R6 runtime disable keeps awake", reg_en, 1);
    soft_rst = 1'b1; tick(); soft_rst = 1'b0;
    tick(5);
    check("R6 soft reset re-enables auto-sleep", reg_en, 0);

    // R6: wake sets the runtime enable again
    wake_seq(G, 0);
    aslp_wr = 1'b1; aslp_wd = 1'b0; tick(); aslp_wr = 1'b0;
    sleep_op = 1'b1; tick(); sleep_op = 1'b0;
    tick(10);
    wake_seq(G, 0);
    tick(IDLE + 40);
    check("R6 wake re-enables auto-sleep", reg_en, 0);

    // R7: configuration disable
    cfg_aslp = 1'b0;
    wake_seq(G, 0);
    tick(IDLE + 40);
    check("R7 config bit keeps awake", reg_en, 1);
    cfg_aslp = 1'b1;
    tick(5);
    check("R7 sleeps once config bit set", reg_en, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule